// File: doc/BRIEF.md
# Staggered-Carrier Modulator for a Chain of H-Bridge Cells

This block produces the gate commands for one phase leg built from a chain of identical H-bridge cells connected in series. One signed reference sample is shared by every cell. Each cell compares that reference against its own triangular carrier. All carriers have the same shape and period. Each one leads the carrier of the cell before it by a fixed fraction of the period, so the carriers are spread evenly across half a carrier cycle (180/CELLS degrees apart).

Each cell uses a three-level scheme. The first arm follows the reference and the second arm follows the negated reference, both compared against the same carrier. The result is one of three cell states: positive, negative or zero. The zero state can be built in two ways, and the block alternates between them. The signed sum of all cell states is reported as the output step level, in the range -CELLS to +CELLS.

The carrier rate is set at run time with a segment length, counted in clock ticks. One segment is the stagger between neighbouring cells. Half a carrier period is CELLS segments.

Top module: `hbridge_chain_mod`

## Requirements
- R1: With P = CELLS * seg (where seg is `seg_len`, and a `seg_len` of 0 counts as 1), the reference is a signed number whose full scale is ±P. For each cell with carrier value c, arm one is high when ref > 2c−P, and arm two is high when −ref > 2c−P. The cell state is +1 when only arm one is high, −1 when only arm two is high, and 0 otherwise.
- R2: A shared phase counter runs from 0 up to 2P−1 and advances by one each clock. It returns to 0 on the clock after it holds a value ≥ 2P−1. Cell k uses the phase (ph + k·seg) mod 2P. Its carrier is c = phase when phase < P, and c = 2P − phase otherwise.
- R3: Cell k owns gate bits 4k..4k+3, in this order: arm-one upper, arm-one lower, arm-two upper, arm-two lower. State +1 drives arm-one upper and arm-two lower (pattern 4'b1001). State −1 drives arm-one lower and arm-two upper (pattern 4'b0110).
- R4: In every cycle, each arm's lower gate is the inverse of that arm's upper gate.
- R5: Zero is shown either as both upper gates on (4'b0101, when the choice bit is 1) or as both lower gates on (4'b1010, when the choice bit is 0). Each cell's choice bit flips every time the cell enters zero from a non-zero state. It is 0 after reset.
- R6: `level` is the signed sum of all cell states and always lies within ±CELLS.
- R7: A cell's state is registered at a clock edge. It uses the reference present at that edge and the phase counter value held just before that edge.
- R8: While reset is held and right after it, the phase counter is 0, every cell shows 4'b1010 and `level` is 0.
- R9: A reference of 0 puts every cell in zero, so `level` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed reference sample, full scale ±CELLS·seg |
| seg_len | input | SEG_W | Carrier stagger in ticks (0 counts as 1) |
| gates | output | 4·CELLS | Gate commands, four bits per cell |
| level | output | LW | Signed sum of the cell states |

## Verification
A wrong phase offset or wrong carrier fold does not stay hidden: the gate pattern of the affected cell moves away from the reference model within one carrier period, because every phase point is visited in each period. A wrong zero-choice bit shows up as 4'b0101 in place of 4'b1010 (or the reverse) at the next entry into zero. A wrong sign or a broken arm pairing shows up at once, in both the gate bits and `level`. The bench compares every cell and the level on every cycle, over whole periods and for several segment lengths.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
   typedef enum logic [1:0] {
      CST_ZERO = 2'b00,
      CST_POS  = 2'b01,
      CST_NEG  = 2'b11
   } cell_st_e;

   function automatic int st_weight(input cell_st_e s);
      case (s)
         CST_POS: st_weight = 1;
         CST_NEG: st_weight = -1;
         default: st_weight = 0;
      endcase
   endfunction
endpackage

// File: rtl/hbc_phase_ctr.sv
module hbc_phase_ctr #(
   parameter int CELLS = 4,
   parameter int SEG_W = 6,
   localparam int PW   = SEG_W + $clog2(CELLS),
   localparam int PHW  = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEG_W-1:0] seg_len,
   output logic [SEG_W-1:0] seg_eff,
   output logic [PW-1:0]    p_half,
   output logic [PHW-1:0]   ph
);
   logic [PHW-1:0] two_p;

   assign seg_eff = (seg_len == '0) ? SEG_W'(1) : seg_len;
   assign p_half  = PW'(CELLS) * PW'(seg_eff);
   assign two_p   = {p_half, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= '0;
      else if (ph >= two_p - 1'b1)
         ph <= '0;
      else
         ph <= ph + 1'b1;
   end

   // R2: any non-zero phase comes from a single step of the previous value
   p_ph_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != '0) |-> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/hbc_cell.sv
module hbc_cell import hbc_pkg::*; #(
   parameter int CELLS = 4,
   parameter int IDX   = 0,
   parameter int SEG_W = 6,
   parameter int REF_W = 10,
   localparam int PW   = SEG_W + $clog2(CELLS),
   localparam int PHW  = PW + 1,
   localparam int CW   = ((REF_W > PW + 2) ? REF_W : PW + 2) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PHW-1:0]          ph,
   input  logic [SEG_W-1:0]        seg_eff,
   input  logic [PW-1:0]           p_half,
   input  logic signed [REF_W-1:0] ref_in,
   output logic [3:0]              gate,
   output cell_st_e                st
);
   logic [PW-1:0]         off_w;
   logic [PHW:0]          ph_sum;
   logic [PHW-1:0]        two_p;
   logic [PHW-1:0]        cph;
   logic [PW-1:0]         tri_v;
   logic signed [CW-1:0]  car_s;
   logic signed [CW-1:0]  ref_s;
   logic signed [CW-1:0]  nref_s;
   logic                  arm_a;
   logic                  arm_b;
   cell_st_e              st_nxt;
   logic                  zsel;

   // carrier position of this cell
   generate
      if (IDX == 0) begin : g_lead
         assign off_w = '0;
      end else begin : g_lag
         assign off_w = PW'(IDX) * PW'(seg_eff);
      end
   endgenerate

   assign two_p  = {p_half, 1'b0};
   assign ph_sum = {1'b0, ph} + (PHW+1)'(off_w);

   always_comb begin
      if (ph_sum >= {1'b0, two_p})
         cph = PHW'(ph_sum - {1'b0, two_p});
      else
         cph = PHW'(ph_sum);
      if (cph < {1'b0, p_half})
         tri_v = PW'(cph);
      else
         tri_v = PW'(two_p - cph);
   end

   // three-level comparison
   assign car_s  = $signed({{(CW-PW-1){1'b0}}, tri_v, 1'b0})
                 - $signed({{(CW-PW){1'b0}}, p_half});
   assign ref_s  = {{(CW-REF_W){ref_in[REF_W-1]}}, ref_in};
   assign nref_s = -ref_s;
   assign arm_a  = (ref_s > car_s);
   assign arm_b  = (nref_s > car_s);

   always_comb begin
      if (arm_a && !arm_b)
         st_nxt = CST_POS;
      else if (arm_b && !arm_a)
         st_nxt = CST_NEG;
      else
         st_nxt = CST_ZERO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= CST_ZERO;
         zsel <= 1'b0;
      end else begin
         st <= st_nxt;
         if (st_nxt == CST_ZERO && st != CST_ZERO)
            zsel <= ~zsel;
      end
   end

   // gate order: [0] arm-one upper, [1] arm-one lower, [2] arm-two upper, [3] arm-two lower
   always_comb begin
      case (st)
         CST_POS: gate = 4'b1001;
         CST_NEG: gate = 4'b0110;
         default: gate = zsel ? 4'b0101 : 4'b1010;
      endcase
   end

   p_arm_compl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate[1] == ~gate[0]) && (gate[3] == ~gate[2]));

   p_zero_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) != CST_ZERO && st == CST_ZERO) |-> (zsel != $past(zsel)));

   p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == CST_ZERO) |-> (zsel == $past(zsel)));

   p_ref_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ref_in) == '0) |-> (st == CST_ZERO));
endmodule

// File: rtl/hbc_level_sum.sv
module hbc_level_sum import hbc_pkg::*; #(
   parameter int CELLS = 4,
   localparam int LW   = $clog2(CELLS + 1) + 1
) (
   input  logic [CELLS-1:0][1:0] st_bits,
   output logic signed [LW-1:0]  level
);
   int acc;

   always_comb begin
      acc = 0;
      for (int k = 0; k < CELLS; k++)
         acc = acc + st_weight(cell_st_e'(st_bits[k]));
      level = LW'(acc);
   end
endmodule

// File: rtl/hbridge_chain_mod.sv
module hbridge_chain_mod import hbc_pkg::*; #(
   parameter int CELLS = 4,
   parameter int SEG_W = 6,
   parameter int REF_W = 10,
   localparam int PW   = SEG_W + $clog2(CELLS),
   localparam int PHW  = PW + 1,
   localparam int LW   = $clog2(CELLS + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic [SEG_W-1:0]        seg_len,
   output logic [4*CELLS-1:0]      gates,
   output logic signed [LW-1:0]    level
);
   generate
      if (CELLS < 1 || CELLS > 64) begin : g_bad_cells
         $error("CELLS must lie in 1..64");
      end
      if (SEG_W < 1) begin : g_bad_seg
         $error("SEG_W must be at least 1");
      end
      if (REF_W < PW + 1) begin : g_bad_ref
         $error("REF_W too narrow to hold the full-scale reference");
      end
   endgenerate

   logic [SEG_W-1:0]       seg_eff;
   logic [PW-1:0]          p_half;
   logic [PHW-1:0]         ph;
   logic [CELLS-1:0][1:0]  st_bits;

   hbc_phase_ctr #(.CELLS(CELLS), .SEG_W(SEG_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .seg_len (seg_len),
      .seg_eff (seg_eff),
      .p_half  (p_half),
      .ph      (ph)
   );

   generate
      for (genvar k = 0; k < CELLS; k++) begin : g_cell
         cell_st_e st_k;
         hbc_cell #(
            .CELLS (CELLS),
            .IDX   (k),
            .SEG_W (SEG_W),
            .REF_W (REF_W)
         ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ph      (ph),
            .seg_eff (seg_eff),
            .p_half  (p_half),
            .ref_in  (ref_in),
            .gate    (gates[4*k +: 4]),
            .st      (st_k)
         );
         assign st_bits[k] = st_k;
      end
   endgenerate

   hbc_level_sum #(.CELLS(CELLS)) u_sum (
      .st_bits (st_bits),
      .level   (level)
   );

   p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= LW'(CELLS)) && (level >= -LW'(CELLS)));

   p_level_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ref_in) == '0) |-> (level == '0));
endmodule

// File: tb/hbridge_chain_mod_tb.sv
module hbridge_chain_mod_tb;
   localparam int CELLS = 4;
   localparam int SEG_W = 6;
   localparam int REF_W = 10;
   localparam int LW    = $clog2(CELLS + 1) + 1;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic signed [REF_W-1:0] ref_in = '0;
   logic [SEG_W-1:0]        seg_len = 6'd8;
   logic [4*CELLS-1:0]      gates;
   logic signed [LW-1:0]    level;

   int n_cmp = 0;
   int n_bad = 0;
   int m_ph = 0;
   int m_st [CELLS];
   bit m_z  [CELLS];
   int seen_up = 0;
   int seen_dn = 0;

   always #10 clk = ~clk;

   hbridge_chain_mod #(.CELLS(CELLS), .SEG_W(SEG_W), .REF_W(REF_W)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_in  (ref_in),
      .seg_len (seg_len),
      .gates   (gates),
      .level   (level)
   );

   function automatic logic [3:0] exp_gate(input int s, input bit z);
      if (s == 1)       return 4'b1001;
      else if (s == -1) return 4'b0110;
      else              return z ? 4'b0101 : 4'b1010;
   endfunction

   task automatic cmp(input string tag);
      int sum = 0;
      for (int k = 0; k < CELLS; k++) begin
         logic [3:0] a;
         logic [3:0] e;
         a = gates[4*k +: 4];
         e = exp_gate(m_st[k], m_z[k]);
         sum += m_st[k];
         n_cmp++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s cell%0d gates actual=%b expected=%b", tag, k, a, e);
         end
         n_cmp++;
         if (a[1] !== ~a[0] || a[3] !== ~a[2]) begin
            n_bad++;
            $display("FAIL R4 cell%0d arm pairing actual=%b expected=complementary arms", k, a);
         end
      end
      n_cmp++;
      if (int'(level) !== sum) begin
         n_bad++;
         $display("FAIL %s R6 level actual=%0d expected=%0d", tag, level, sum);
      end
   endtask

   // one clock step of the model, then compare at the following falling edge
   task automatic tick(input string tag);
      int seg;
      int p;
      int r;
      seg = (seg_len == 0) ? 1 : int'(seg_len);
      p   = CELLS * seg;
      r   = int'(ref_in);
      for (int k = 0; k < CELLS; k++) begin
         int phs;
         int c;
         int ns;
         bit a;
         bit b;
         phs = (m_ph + k * seg) % (2 * p);
         c   = (phs < p) ? phs : 2 * p - phs;
         a   = (r > 2 * c - p);
         b   = (-r > 2 * c - p);
         ns  = (a && !b) ? 1 : ((b && !a) ? -1 : 0);
         if (ns == 0 && m_st[k] != 0) m_z[k] = ~m_z[k];
         m_st[k] = ns;
      end
      m_ph = (m_ph >= 2 * p - 1) ? 0 : m_ph + 1;
      @(posedge clk);
      @(negedge clk);
      if (gates[3:0] == 4'b0101) seen_up++;
      if (gates[3:0] == 4'b1010) seen_dn++;
      cmp(tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_ph = 0;
      for (int k = 0; k < CELLS; k++) begin
         m_st[k] = 0;
         m_z[k]  = 1'b0;
      end
      repeat (2) @(negedge clk);
      cmp("R8 during reset");
      rst_n = 1'b1;
   endtask

   function automatic int period2();
      int seg;
      seg = (seg_len == 0) ? 1 : int'(seg_len);
      return 2 * CELLS * seg;
   endfunction

   task automatic t_reset();
      seg_len = 6'd8;
      ref_in  = 10'sd77;
      do_reset();
      cmp("R8 after release");
   endtask

   task automatic t_zero_ref();
      ref_in = '0;
      for (int i = 0; i < 2 * period2(); i++) tick("R9 R1");
   endtask

   task automatic t_const(input int v, input string tag);
      ref_in = REF_W'(v);
      for (int i = 0; i < 2 * period2(); i++) tick(tag);
   endtask

   task automatic t_ramp();
      int p;
      p = period2() / 2;
      for (int v = -p; v <= p; v += 2) begin
         ref_in = REF_W'(v);
         tick("R7 R2 ramp");
      end
      for (int v = p; v >= -p; v -= 3) begin
         ref_in = REF_W'(v);
         tick("R7 R1 ramp down");
      end
   endtask

   task automatic t_seg(input int s);
      seg_len = SEG_W'(s);
      ref_in  = REF_W'(period2() / 4 + 1);
      do_reset();
      for (int i = 0; i < 3 * period2(); i++) tick("R2 segment length");
      ref_in = REF_W'(-(period2() / 3));
      for (int i = 0; i < 2 * period2(); i++) tick("R2 R3 segment length");
   endtask

   task automatic t_zero_alt();
      seg_len = 6'd8;
      ref_in  = 10'sd12;
      do_reset();
      seen_up = 0;
      seen_dn = 0;
      for (int i = 0; i < 3 * period2(); i++) tick("R5 alternation");
      n_cmp++;
      if (seen_up == 0 || seen_dn == 0) begin
         n_bad++;
         $display("FAIL R5 zero variants on cell0 actual=up%0d/down%0d expected=both non-zero",
                  seen_up, seen_dn);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_zero_ref();
      t_const(10, "R1 R2 R3 R7 positive");
      t_const(-20, "R1 R3 R6 negative");
      t_const(32, "R1 R6 full scale up");
      t_const(-32, "R1 R6 full scale down");
      t_ramp();
      t_seg(0);
      t_seg(3);
      t_seg(13);
      t_zero_alt();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule